// File: doc/BRIEF.md
# Floppy Controller Glue and Image Sector Offset

This block is the register glue around a floppy disk controller core. The CPU writes a drive-select register and a density/side register. It reads a status byte that shows the controller's interrupt and data-request lines. From these settings the block drives the drive select, the recording density, the side and the track geometry toward the controller and the disk image store.

The block also computes the byte position of a sector inside a flat disk image. On that image, track 0 side 0 is recorded with 128-byte FM sectors and every other track with 256-byte MFM sectors. Both layouts fold into one formula, with a fixed correction of 2048 bytes. That value is the size difference between one MFM track (17 × 256) and one FM track (18 × 128).

A small classifier checks the size of an image when it is attached. It reports whether the image is single-sided, double-sided or not usable.

Top module: `fdc_glue_top`

## Requirements
- R1: A drive-select write whose data bits 1:0 equal 01 selects drive 0 (`drv_sel_o`=0), and 10 selects drive 1 (`drv_sel_o`=1). The change is visible one cycle after the write strobe. After reset, drive 0 is selected.
- R2: A drive-select write whose bits 1:0 equal 00 or 11 leaves `drv_sel_o` unchanged.
- R3: A density/side write latches data bit 0 into `fm_o` (1 = FM, 0 = MFM) and data bit 1 into `side_o` (1 = side 1). After reset both are 0.
- R4: With `fm_o`=1 the geometry reads 18 sectors of 128 bytes. With `fm_o`=0 it reads 17 sectors of 256 bytes. The track count is always 40. `heads_o` equals the head count of the selected drive, taken from `drv_heads_i[2n+1:2n]` for drive n.
- R5: `stat_o` bit 7 equals the IRQ line and bit 6 equals the DRQ line, each after a two-flop synchronizer, so the output follows the input by two clock edges. Bits 5:0 are 0.
- R6: For a request on track 0, head 0, the offset is (sector − 1) × 128. Sector IDs start at 1.
- R7: For any other track or head, the offset is ((track × heads + head) × 17 + sector − 1) × 256 − 2048. Here heads is the head count of the selected drive.
- R8: `off_valid_o` is high exactly in the cycle after a cycle with `req_valid_i` high, and `off_o` holds that request's offset in the same cycle.
- R9: An image size of 172032 bytes gives `img_ok_o`=1 and `img_heads_o`=1. A size of 346112 bytes gives `img_ok_o`=1 and `img_heads_o`=2. Any other size gives `img_ok_o`=0 and `img_heads_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_drv_i | input | 1 | Drive-select register write strobe |
| wr_dens_i | input | 1 | Density/side register write strobe |
| wdata_i | input | 8 | CPU write data |
| stat_o | output | 8 | Status byte: bit 7 IRQ, bit 6 DRQ |
| fdc_irq_i | input | 1 | Controller interrupt line (asynchronous) |
| fdc_drq_i | input | 1 | Controller data request line (asynchronous) |
| drv_heads_i | input | 4 | Head count per drive, 2 bits each, drive n at [2n+1:2n] |
| drv_sel_o | output | 1 | Selected drive |
| fm_o | output | 1 | 1 = FM density, 0 = MFM |
| side_o | output | 1 | Selected side |
| spt_o | output | 5 | Sectors per track |
| sec_len_o | output | 9 | Sector length in bytes |
| tracks_o | output | 6 | Track count |
| heads_o | output | 2 | Head count of selected drive |
| req_valid_i | input | 1 | Offset request valid |
| req_track_i | input | 6 | Requested track |
| req_head_i | input | 1 | Requested head |
| req_sector_i | input | 5 | Requested sector ID |
| off_valid_o | output | 1 | Offset result valid |
| off_o | output | 20 | Byte offset in the image |
| img_size_i | input | 20 | Image size in bytes |
| img_ok_o | output | 1 | Image size accepted |
| img_heads_o | output | 2 | Sides implied by the image size, 0 if rejected |

## Verification
The assertions check every cycle that reserved drive-select codes keep the selection, and that a density write lands in the next cycle. They also check that the geometry always matches the density, and that the result-valid flag follows the request by exactly one cycle. The offset values themselves, the track 0 side 0 boundary, the switch to the other drive's head count, the synchronizer delay on the status byte and the image-size classes are shown only by the bench's directed and random scenarios.

// File: rtl/fdc_glue_pkg.sv
package fdc_glue_pkg;
  localparam int unsigned NUM_DRV   = 2;
  localparam int unsigned TRK_W     = 6;
  localparam int unsigned SEC_W     = 5;
  localparam int unsigned HEAD_CW   = 2;
  localparam int unsigned OFF_W     = 20;
  localparam int unsigned IMG_W     = 20;
  localparam int unsigned NUM_TRK   = 40;
  localparam int unsigned SPT_FM    = 18;
  localparam int unsigned SPT_MFM   = 17;
  localparam int unsigned LEN_FM_LG = 7;
  localparam int unsigned LEN_MFM_LG = 8;
  localparam int unsigned FIRST_ID  = 1;
  localparam int unsigned SS_BYTES  = 172032;
  localparam int unsigned DS_BYTES  = 346112;

  typedef enum logic [1:0] {
    SEL_KEEP0 = 2'b00,
    SEL_DRV0  = 2'b01,
    SEL_DRV1  = 2'b10,
    SEL_KEEP3 = 2'b11
  } sel_code_e;
endpackage

// File: rtl/fdc_glue_regs.sv
module fdc_glue_regs
  import fdc_glue_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_drv_i,
  input  logic       wr_dens_i,
  input  logic [7:0] wdata_i,
  input  logic       fdc_irq_i,
  input  logic       fdc_drq_i,
  output logic       drv_sel_o,
  output logic       fm_o,
  output logic       side_o,
  output logic [7:0] stat_o
);
  logic [1:0] irq_q, drq_q;
  sel_code_e  code;

  assign code = sel_code_e'(wdata_i[1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= '0;
      drq_q <= '0;
    end else begin
      irq_q <= {irq_q[0], fdc_irq_i};
      drq_q <= {drq_q[0], fdc_drq_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_sel_o <= 1'b0;
    end else if (wr_drv_i) begin
      case (code)
        SEL_DRV0: drv_sel_o <= 1'b0;
        SEL_DRV1: drv_sel_o <= 1'b1;
        default:  drv_sel_o <= drv_sel_o;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fm_o   <= 1'b0;
      side_o <= 1'b0;
    end else if (wr_dens_i) begin
      fm_o   <= wdata_i[0];
      side_o <= wdata_i[1];
    end
  end

  assign stat_o = {irq_q[1], drq_q[1], 6'b0};

  assert_sel_keep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_drv_i && (wdata_i[1:0] == 2'b00 || wdata_i[1:0] == 2'b11)) |=> $stable(drv_sel_o));

  assert_sel_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_drv_i && wdata_i[1:0] == 2'b10) |=> drv_sel_o);

  assert_dens_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dens_i |=> (fm_o == $past(wdata_i[0]) && side_o == $past(wdata_i[1])));
endmodule

// File: rtl/fdc_glue_geom.sv
module fdc_glue_geom
  import fdc_glue_pkg::*;
(
  input  logic                       fm_i,
  input  logic                       drv_sel_i,
  input  logic [NUM_DRV*HEAD_CW-1:0] drv_heads_i,
  output logic [SEC_W-1:0]           spt_o,
  output logic [8:0]                 sec_len_o,
  output logic [TRK_W-1:0]           tracks_o,
  output logic [HEAD_CW-1:0]         heads_o
);
  logic [HEAD_CW-1:0] heads_a [NUM_DRV];

  for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
    assign heads_a[d] = drv_heads_i[d*HEAD_CW +: HEAD_CW];
  end

  assign spt_o     = fm_i ? SEC_W'(SPT_FM) : SEC_W'(SPT_MFM);
  assign sec_len_o = fm_i ? 9'(1 << LEN_FM_LG) : 9'(1 << LEN_MFM_LG);
  assign tracks_o  = TRK_W'(NUM_TRK);
  assign heads_o   = heads_a[drv_sel_i];
endmodule

// File: rtl/fdc_glue_offset.sv
module fdc_glue_offset
  import fdc_glue_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [TRK_W-1:0]   req_track_i,
  input  logic               req_head_i,
  input  logic [SEC_W-1:0]   req_sector_i,
  input  logic [HEAD_CW-1:0] heads_i,
  output logic               off_valid_o,
  output logic [OFF_W-1:0]   off_o
);
  localparam int unsigned CORR = SPT_MFM * (1 << LEN_MFM_LG) - SPT_FM * (1 << LEN_FM_LG);

  logic [OFF_W-1:0] lin, idx, off_n;
  logic             boot_trk;

  assign boot_trk = (req_track_i == '0) && !req_head_i;

  always_comb begin
    lin = OFF_W'(req_track_i) * OFF_W'(heads_i) + OFF_W'(req_head_i);
    idx = lin * OFF_W'(SPT_MFM) + OFF_W'(req_sector_i) - OFF_W'(FIRST_ID);
    if (boot_trk) off_n = (OFF_W'(req_sector_i) - OFF_W'(FIRST_ID)) << LEN_FM_LG;
    else          off_n = (idx << LEN_MFM_LG) - OFF_W'(CORR);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_valid_o <= 1'b0;
      off_o       <= '0;
    end else begin
      off_valid_o <= req_valid_i;
      if (req_valid_i) off_o <= off_n;
    end
  end

  assert_valid_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> off_valid_o);

  assert_valid_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !off_valid_o);
endmodule

// File: rtl/fdc_glue_imgchk.sv
module fdc_glue_imgchk
  import fdc_glue_pkg::*;
(
  input  logic [IMG_W-1:0]   img_size_i,
  output logic               img_ok_o,
  output logic [HEAD_CW-1:0] img_heads_o
);
  always_comb begin
    if (img_size_i == IMG_W'(SS_BYTES))      img_heads_o = HEAD_CW'(1);
    else if (img_size_i == IMG_W'(DS_BYTES)) img_heads_o = HEAD_CW'(2);
    else                                     img_heads_o = '0;
    img_ok_o = (img_heads_o != '0);
  end
endmodule

// File: rtl/fdc_glue_top.sv
module fdc_glue_top
  import fdc_glue_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_drv_i,
  input  logic                       wr_dens_i,
  input  logic [7:0]                 wdata_i,
  output logic [7:0]                 stat_o,
  input  logic                       fdc_irq_i,
  input  logic                       fdc_drq_i,
  input  logic [NUM_DRV*HEAD_CW-1:0] drv_heads_i,
  output logic                       drv_sel_o,
  output logic                       fm_o,
  output logic                       side_o,
  output logic [SEC_W-1:0]           spt_o,
  output logic [8:0]                 sec_len_o,
  output logic [TRK_W-1:0]           tracks_o,
  output logic [HEAD_CW-1:0]         heads_o,
  input  logic                       req_valid_i,
  input  logic [TRK_W-1:0]           req_track_i,
  input  logic                       req_head_i,
  input  logic [SEC_W-1:0]           req_sector_i,
  output logic                       off_valid_o,
  output logic [OFF_W-1:0]           off_o,
  input  logic [IMG_W-1:0]           img_size_i,
  output logic                       img_ok_o,
  output logic [HEAD_CW-1:0]         img_heads_o
);
  fdc_glue_regs i_regs (
    .clk_i, .rst_ni, .wr_drv_i, .wr_dens_i, .wdata_i,
    .fdc_irq_i, .fdc_drq_i, .drv_sel_o, .fm_o, .side_o, .stat_o
  );

  fdc_glue_geom i_geom (
    .fm_i(fm_o), .drv_sel_i(drv_sel_o), .drv_heads_i,
    .spt_o, .sec_len_o, .tracks_o, .heads_o
  );

  fdc_glue_offset i_off (
    .clk_i, .rst_ni, .req_valid_i, .req_track_i, .req_head_i, .req_sector_i,
    .heads_i(heads_o), .off_valid_o, .off_o
  );

  fdc_glue_imgchk i_img (.img_size_i, .img_ok_o, .img_heads_o);

  assert_geom_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fm_o ? (spt_o == SEC_W'(SPT_FM) && sec_len_o == 9'd128)
         : (spt_o == SEC_W'(SPT_MFM) && sec_len_o == 9'd256));
endmodule

// File: tb/test_fdc_glue_top.sv
module test_fdc_glue_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_drv = 0, wr_dens = 0, irq = 0, drq = 0, req_v = 0, req_h = 0;
  logic [7:0]  wdata = 0;
  logic [3:0]  dheads = 4'b0110;
  logic [5:0]  req_t = 0;
  logic [4:0]  req_s = 1;
  logic [19:0] img_sz = 0;
  logic [7:0]  stat;
  logic        dsel, fm, side, offv, imok;
  logic [4:0]  spt;
  logic [8:0]  slen;
  logic [5:0]  trks;
  logic [1:0]  hds, imh;
  logic [19:0] off;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  fdc_glue_top i_fdc_glue_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_drv_i(wr_drv), .wr_dens_i(wr_dens), .wdata_i(wdata),
    .stat_o(stat), .fdc_irq_i(irq), .fdc_drq_i(drq), .drv_heads_i(dheads),
    .drv_sel_o(dsel), .fm_o(fm), .side_o(side), .spt_o(spt), .sec_len_o(slen),
    .tracks_o(trks), .heads_o(hds), .req_valid_i(req_v), .req_track_i(req_t),
    .req_head_i(req_h), .req_sector_i(req_s), .off_valid_o(offv), .off_o(off),
    .img_size_i(img_sz), .img_ok_o(imok), .img_heads_o(imh)
  );

  function automatic int exp_off(int t, int h, int s, int nh);
    if (t == 0 && h == 0) return (s - 1) * 128;
    return ((t * nh + h) * 17 + s - 1) * 256 - 2048;
  endfunction

  function automatic int exp_imh(int sz);
    if (sz == 172032) return 1;
    if (sz == 346112) return 2;
    return 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(bit dens, logic [7:0] d);
    @(negedge clk);
    wdata = d; wr_drv = !dens; wr_dens = dens;
    @(negedge clk);
    wr_drv = 0; wr_dens = 0;
  endtask

  task automatic do_req(int t, int h, int s, int nh);
    @(negedge clk);
    req_t = 6'(t); req_h = h[0]; req_s = 5'(s); req_v = 1;
    @(negedge clk);
    req_v = 0;
    chk(t == 0 && h == 0 ? "R6" : "R7", int'(off), exp_off(t, h, s, nh));
    chk("R8 valid", int'(offv), 1);
    @(negedge clk);
    chk("R8 idle", int'(offv), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk("R1 reset sel", int'(dsel), 0);
    chk("R3 reset fm", int'(fm), 0);
    chk("R3 reset side", int'(side), 0);
    chk("R5 reset stat", int'(stat), 0);
    chk("R8 reset valid", int'(offv), 0);

    // drive select
    wr(0, 8'h02); chk("R1 sel drv1", int'(dsel), 1);
    chk("R4 heads drv1", int'(hds), 1);
    wr(0, 8'hF3); chk("R2 keep 11", int'(dsel), 1);
    wr(0, 8'h00); chk("R2 keep 00", int'(dsel), 1);
    wr(0, 8'h01); chk("R1 sel drv0", int'(dsel), 0);
    chk("R4 heads drv0", int'(hds), 2);
    wr(0, 8'hFC); chk("R2 keep 00 hi", int'(dsel), 0);

    // density / geometry
    wr(1, 8'h01);
    chk("R3 fm", int'(fm), 1); chk("R3 side0", int'(side), 0);
    chk("R4 spt fm", int'(spt), 18); chk("R4 len fm", int'(slen), 128);
    chk("R4 tracks", int'(trks), 40);
    wr(1, 8'h02);
    chk("R3 mfm", int'(fm), 0); chk("R3 side1", int'(side), 1);
    chk("R4 spt mfm", int'(spt), 17); chk("R4 len mfm", int'(slen), 256);

    // status sync
    @(negedge clk); irq = 1; drq = 0;
    @(negedge clk); chk("R5 irq early", int'(stat), 0);
    @(negedge clk); chk("R5 irq", int'(stat), 8'h80);
    drq = 1; irq = 0;
    @(negedge clk); @(negedge clk); chk("R5 drq", int'(stat), 8'h40);
    irq = 1;
    @(negedge clk); @(negedge clk); chk("R5 both", int'(stat), 8'hC0);
    irq = 0; drq = 0;

    // offset corners, drive 0 double sided
    do_req(0, 0, 1, 2);
    do_req(0, 0, 18, 2);
    do_req(0, 1, 1, 2);
    do_req(1, 0, 1, 2);
    do_req(39, 1, 17, 2);
    // drive 1 single sided
    wr(0, 8'h02);
    do_req(1, 0, 1, 1);
    do_req(39, 0, 17, 1);

    // random
    for (int i = 0; i < 200; i++) begin
      int d, nh, t, h, s;
      d  = int'($urandom_range(0, 1));
      @(negedge clk);
      dheads = {2'($urandom_range(1, 2)), 2'($urandom_range(1, 2))};
      wr(0, d ? 8'h02 : 8'h01);
      nh = d ? int'(dheads[3:2]) : int'(dheads[1:0]);
      chk("R4 heads rnd", int'(hds), nh);
      t = int'($urandom_range(0, 39));
      h = (nh == 2) ? int'($urandom_range(0, 1)) : 0;
      s = (t == 0 && h == 0) ? int'($urandom_range(1, 18)) : int'($urandom_range(1, 17));
      do_req(t, h, s, nh);
    end

    // back-to-back requests
    @(negedge clk);
    dheads = 4'b1010; req_v = 1; req_t = 6'd5; req_h = 1; req_s = 5'd3;
    @(negedge clk);
    chk("R7 b2b first", int'(off), exp_off(5, 1, 3, 2));
    req_t = 6'd0; req_h = 0; req_s = 5'd7;
    @(negedge clk);
    req_v = 0;
    chk("R6 b2b second", int'(off), exp_off(0, 0, 7, 2));
    chk("R8 b2b valid", int'(offv), 1);

    // image size
    begin
      int sizes [6] = '{172032, 346112, 0, 172031, 346113, 172032 * 2};
      foreach (sizes[k]) begin
        @(negedge clk); img_sz = 20'(sizes[k]);
        #1;
        chk("R9 heads", int'(imh), exp_imh(sizes[k]));
        chk("R9 ok", int'(imok), exp_imh(sizes[k]) != 0 ? 1 : 0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule